// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog with a small synchronous register bus. A slow tick enable, which pulses once every 0.6 s, drives a down-counter. A timeout of N seconds is therefore programmed as N*10/6 ticks in the timer value register. Software writes the reload register to restart the count, and it uses a halt bit to freeze or resume counting. The current count can be read back at the reload address.

When the count runs out the first time, the block sets a timeout flag and reloads itself. If the count runs out again before software reloads it, the block sets a second-timeout flag and a boot flag, and it sets the timeout flag again. It also raises a one-cycle reset request, unless the no-reboot input is high.

The status flags are write-one-to-clear. A lock bit in the first control register cannot be cleared once software sets it. Writing either byte of the data mailbox word sets two software status flags. The bus addresses 16-bit words with a word index, and each byte lane has its own enable.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, the registers read as follows, by word index:
  - 0 (counter): 0
  - 1 (mailbox): 0
  - 2 (status A): 0
  - 3 (status B): 0
  - 4 (control A): 0
  - 5 (control B): 0x0008
  - 6 (messages): 0
  - 7 (watchdog count): 0
  - 8 (software IRQ): 0x0003
  - 9 (timer value): 0x0004
- R2: Any write to word 0 loads the counter from the effective timer value, whatever data is written. It also restarts the expiry sequence at the first stage.
- R3: While running, the counter at word 0 drops by exactly one on each tick-enable pulse.
- R4: While the halt bit (bit 11 of word 4) is 1, ticks leave the counter unchanged. Clearing the bit lets counting resume.
- R5: From a loaded value N, the counter reads 1 after N-1 ticks and no timeout has occurred. The next tick sets the timeout flag (bit 3 of word 2) and reloads N.
- R6: A second expiry with no reload in between sets bit 1 (second timeout) and bit 2 (boot) of word 3, and sets bit 3 of word 2. This happens even if software cleared bit 3 after the first expiry.
- R7: On a second expiry, reset_req pulses high for exactly one cycle if no_reboot is 0. It stays low if no_reboot is 1, and at all other times.
- R8: Status bits clear only where 1 is written, within enabled bytes. Writing back the value just read leaves the register reading 0.
- R9: A write to the low byte of word 1 (data-in) or its high byte (data-out) stores that byte. It also sets bit 1 (software SMI) and bit 2 (interrupt) of word 2.
- R10: The lock bit (bit 12 of word 4) sets when 1 is written to it. Writing 0 to it has no effect until reset.
- R11: The timer value is masked to TMR_W bits (10 by default), so writing 0xFFFF reads back 0x03FF. A timer value of 0 or 1 loads 2.
- R12: A reload between two expiries makes the next expiry a first-stage one. That expiry sets no bit in word 3 and produces no reset request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse per 0.6 s tick |
| no_reboot | input | 1 | Suppresses the reset request on a second expiry |
| bus_we | input | 1 | Write strobe |
| bus_waddr | input | 4 | Word index of the register |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte enables, bit 0 for the low byte |
| rd_data | output | 16 | Read data for bus_waddr, combinational |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
A wrong counter state shows at word 0 on the same cycle as the tick that caused it, because the read path is combinational. A wrong stage flag stays hidden until the following expiry. At that point word 3 and reset_req disagree with the expected value either one full timeout too early or too late, so the bench runs long two-expiry sequences with and without reloads in between. Faults in status clearing or set priority appear at the first read after the write.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
    // word indexes on the register bus
    localparam logic [3:0] W_RLD = 4'd0;
    localparam logic [3:0] W_DAT = 4'd1;
    localparam logic [3:0] W_STA = 4'd2;
    localparam logic [3:0] W_STB = 4'd3;
    localparam logic [3:0] W_CTA = 4'd4;
    localparam logic [3:0] W_CTB = 4'd5;
    localparam logic [3:0] W_MSG = 4'd6;
    localparam logic [3:0] W_WDC = 4'd7;
    localparam logic [3:0] W_IRQ = 4'd8;
    localparam logic [3:0] W_TMR = 4'd9;

    // bit positions
    localparam int B_SMI  = 1;
    localparam int B_INT  = 2;
    localparam int B_TO   = 3;
    localparam int B_SEC  = 1;
    localparam int B_BOOT = 2;
    localparam int B_HALT = 11;
    localparam int B_LOCK = 12;

    // reset values
    localparam logic [15:0] CTB_RST = 16'h0008;
    localparam logic [7:0]  IRQ_RST = 8'h03;
endpackage

// File: rtl/wdog_count.sv
`timescale 1ns/1ps
module wdog_count #(
    parameter int TMR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             halt,
    input  logic             reload,
    input  logic             no_reboot,
    input  logic [TMR_W-1:0] tmr_val,
    output logic [TMR_W-1:0] cnt,
    output logic             exp1,
    output logic             exp2,
    output logic             reset_req
);
    typedef struct packed {
        logic [TMR_W-1:0] cnt;
        logic             armed;
        logic             rst_req;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [TMR_W-1:0] load_val;

    always_comb begin
        load_val = (tmr_val < TMR_W'(2)) ? TMR_W'(2) : tmr_val;
        st_d = st_q;
        st_d.rst_req = 1'b0;
        exp1 = 1'b0;
        exp2 = 1'b0;
        if (reload) begin
            st_d.cnt   = load_val;
            st_d.armed = 1'b0;
        end else if (tick_en && !halt) begin
            if (st_q.cnt <= TMR_W'(1)) begin
                st_d.cnt = load_val;
                if (st_q.armed) begin
                    exp2 = 1'b1;
                    st_d.rst_req = !no_reboot;
                end else begin
                    exp1 = 1'b1;
                    st_d.armed = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt - TMR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt       = st_q.cnt;
    assign reset_req = st_q.rst_req;
endmodule

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int          TMR_W   = 10,
    parameter logic [15:0] TMR_RST = 16'h0004
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [3:0]       bus_waddr,
    input  logic [15:0]      bus_wdata,
    input  logic [1:0]       bus_be,
    input  logic [TMR_W-1:0] cnt,
    input  logic             exp1,
    input  logic             exp2,
    output logic [15:0]      rd_data,
    output logic             halt,
    output logic             reload,
    output logic [TMR_W-1:0] tmr_val
);
    typedef struct packed {
        logic [7:0]       dat_in;
        logic [7:0]       dat_out;
        logic             to_sts;
        logic             smi_sts;
        logic             int_sts;
        logic             sec_sts;
        logic             boot_sts;
        logic             halt;
        logic             lock;
        logic [15:0]      ctb;
        logic [15:0]      msg;
        logic [7:0]       wdc;
        logic [7:0]       irq;
        logic [TMR_W-1:0] tmr;
    } reg_st_t;

    reg_st_t rg_d, rg_q;
    logic [15:0] mask, setb;

    always_comb begin
        mask = {{8{bus_be[1]}}, {8{bus_be[0]}}};
        setb = bus_wdata & mask;
        rg_d = rg_q;
        if (bus_we) begin
            case (bus_waddr)
                W_DAT: begin
                    if (bus_be[0]) begin
                        rg_d.dat_in  = bus_wdata[7:0];
                        rg_d.smi_sts = 1'b1;
                        rg_d.int_sts = 1'b1;
                    end
                    if (bus_be[1]) begin
                        rg_d.dat_out = bus_wdata[15:8];
                        rg_d.smi_sts = 1'b1;
                        rg_d.int_sts = 1'b1;
                    end
                end
                W_STA: begin
                    if (setb[B_TO])  rg_d.to_sts  = 1'b0;
                    if (setb[B_SMI]) rg_d.smi_sts = 1'b0;
                    if (setb[B_INT]) rg_d.int_sts = 1'b0;
                end
                W_STB: begin
                    if (setb[B_SEC])  rg_d.sec_sts  = 1'b0;
                    if (setb[B_BOOT]) rg_d.boot_sts = 1'b0;
                end
                W_CTA: begin
                    if (bus_be[1]) begin
                        rg_d.halt = bus_wdata[B_HALT];
                        rg_d.lock = rg_q.lock | bus_wdata[B_LOCK];
                    end
                end
                W_CTB: rg_d.ctb = (rg_q.ctb & ~mask) | setb;
                W_MSG: rg_d.msg = (rg_q.msg & ~mask) | setb;
                W_WDC: if (bus_be[0]) rg_d.wdc = bus_wdata[7:0];
                W_IRQ: if (bus_be[0]) rg_d.irq = bus_wdata[7:0];
                W_TMR: rg_d.tmr = TMR_W'((16'(rg_q.tmr) & ~mask) | setb);
                default: ;
            endcase
        end
        // hardware set wins over a same-cycle clear
        if (exp1 || exp2) rg_d.to_sts = 1'b1;
        if (exp2) begin
            rg_d.sec_sts  = 1'b1;
            rg_d.boot_sts = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rg_q     <= '0;
            rg_q.ctb <= CTB_RST;
            rg_q.irq <= IRQ_RST;
            rg_q.tmr <= TMR_W'(TMR_RST);
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (bus_waddr)
            W_RLD: rd_data = 16'(cnt);
            W_DAT: rd_data = {rg_q.dat_out, rg_q.dat_in};
            W_STA: begin
                rd_data[B_TO]  = rg_q.to_sts;
                rd_data[B_SMI] = rg_q.smi_sts;
                rd_data[B_INT] = rg_q.int_sts;
            end
            W_STB: begin
                rd_data[B_SEC]  = rg_q.sec_sts;
                rd_data[B_BOOT] = rg_q.boot_sts;
            end
            W_CTA: begin
                rd_data[B_HALT] = rg_q.halt;
                rd_data[B_LOCK] = rg_q.lock;
            end
            W_CTB: rd_data = rg_q.ctb;
            W_MSG: rd_data = rg_q.msg;
            W_WDC: rd_data = {8'h00, rg_q.wdc};
            W_IRQ: rd_data = {8'h00, rg_q.irq};
            W_TMR: rd_data = 16'(rg_q.tmr);
            default: rd_data = '0;
        endcase
    end

    assign halt    = rg_q.halt;
    assign reload  = bus_we && (bus_waddr == W_RLD);
    assign tmr_val = rg_q.tmr;
endmodule

// File: rtl/wdog_two_stage.sv
`timescale 1ns/1ps
module wdog_two_stage #(
    parameter int          TMR_W   = 10,
    parameter logic [15:0] TMR_RST = 16'h0004
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        no_reboot,
    input  logic        bus_we,
    input  logic [3:0]  bus_waddr,
    input  logic [15:0] bus_wdata,
    input  logic [1:0]  bus_be,
    output logic [15:0] rd_data,
    output logic        reset_req
);
    logic [TMR_W-1:0] cnt_w, tmr_w;
    logic             halt_w, reload_w, exp1_w, exp2_w;

    wdog_count #(.TMR_W(TMR_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .halt      (halt_w),
        .reload    (reload_w),
        .no_reboot (no_reboot),
        .tmr_val   (tmr_w),
        .cnt       (cnt_w),
        .exp1      (exp1_w),
        .exp2      (exp2_w),
        .reset_req (reset_req)
    );

    wdog_regs #(.TMR_W(TMR_W), .TMR_RST(TMR_RST)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_waddr (bus_waddr),
        .bus_wdata (bus_wdata),
        .bus_be    (bus_be),
        .cnt       (cnt_w),
        .exp1      (exp1_w),
        .exp2      (exp2_w),
        .rd_data   (rd_data),
        .halt      (halt_w),
        .reload    (reload_w),
        .tmr_val   (tmr_w)
    );
endmodule

// File: rtl/wdog_chk.sv
`timescale 1ns/1ps
module wdog_chk #(
    parameter int TMR_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             no_reboot,
    input logic             reset_req,
    input logic [TMR_W-1:0] cnt,
    input logic             halt,
    input logic             reload,
    input logic             exp1,
    input logic             exp2
);
    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !halt && !reload && cnt > TMR_W'(1)) |=> (cnt == $past(cnt) - TMR_W'(1)));

    p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !reload) |=> $stable(cnt));

    p_reload_after_exp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exp1 |=> (cnt >= TMR_W'(2)));

    p_one_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exp1, exp2}));

    p_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exp2 && !no_reboot) |=> reset_req);

    p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exp2 && no_reboot) |=> !reset_req);

    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !exp2 |=> !reset_req);
endmodule

bind wdog_two_stage wdog_chk #(.TMR_W(TMR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .no_reboot (no_reboot),
    .reset_req (reset_req),
    .cnt       (cnt_w),
    .halt      (halt_w),
    .reload    (reload_w),
    .exp1      (exp1_w),
    .exp2      (exp2_w)
);

// File: tb/wdog_two_stage_tb.sv
`timescale 1ns/1ps
module wdog_two_stage_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        no_reboot = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_waddr = '0;
    logic [15:0] bus_wdata = '0;
    logic [1:0]  bus_be = 2'b11;
    logic [15:0] rd_data;
    logic        reset_req;

    int n_run = 0;
    int n_fail = 0;
    int rr_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdog_two_stage u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .no_reboot(no_reboot),
        .bus_we(bus_we), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .rd_data(rd_data), .reset_req(reset_req)
    );

    always @(negedge clk) if (rst_n && reset_req) rr_cnt++;

    // R1 reset table: {word index, expected value}
    localparam logic [19:0] DEFS [10] = '{
        {4'd0, 16'h0000}, {4'd1, 16'h0000}, {4'd2, 16'h0000}, {4'd3, 16'h0000},
        {4'd4, 16'h0000}, {4'd5, 16'h0008}, {4'd6, 16'h0000}, {4'd7, 16'h0000},
        {4'd8, 16'h0003}, {4'd9, 16'h0004}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        bus_waddr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        bus_waddr = a;
        #1 v = rd_data;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 defaults, walked from the table
        for (int i = 0; i < 10; i++) begin
            rd(DEFS[i][19:16], v);
            chk("R1", v, DEFS[i][15:0]);
        end

        // R2 / R4 halted reload
        wr(4'd4, 16'h0800, 2'b11);
        wr(4'd9, 16'h0008, 2'b11);
        wr(4'd0, 16'hBEEF, 2'b11);
        rd(4'd0, v); chk("R2", v, 16'h0008);
        tick(3);
        rd(4'd0, v); chk("R4 halted", v, 16'h0008);
        wr(4'd4, 16'h0000, 2'b11);
        tick(1);
        rd(4'd0, v); chk("R3/R4 resume", v, 16'h0007);
        tick(6);
        rd(4'd0, v); chk("R3 count 1", v, 16'h0001);
        rd(4'd2, v); chk("R5 no early timeout", v, 16'h0000);
        tick(1);
        rd(4'd2, v); chk("R5 timeout", v, 16'h0008);
        rd(4'd0, v); chk("R5 reload", v, 16'h0008);
        wr(4'd2, 16'h0008, 2'b11);
        rd(4'd2, v); chk("R8 clear", v, 16'h0000);
        tick(8);
        rd(4'd2, v); chk("R6 timeout again", v, 16'h0008);
        rd(4'd3, v); chk("R6 second stage", v, 16'h0006);
        chk("R7 pulse", 16'(rr_cnt), 16'd1);
        wr(4'd3, v, 2'b11);
        rd(4'd3, v); chk("R8 writeback", v, 16'h0000);
        wr(4'd2, 16'hFFFF, 2'b11);

        // R12 reload between expiries
        wr(4'd0, 16'h0000, 2'b01);
        tick(8);
        rd(4'd2, v); chk("R12 first stage", v, 16'h0008);
        wr(4'd0, 16'h1234, 2'b10);
        tick(8);
        rd(4'd3, v); chk("R12 no second stage", v, 16'h0000);
        chk("R12 no reset", 16'(rr_cnt), 16'd1);

        // R7 gated
        no_reboot = 1'b1;
        tick(8);
        rd(4'd3, v); chk("R7 gated stage", v, 16'h0006);
        chk("R7 gated", 16'(rr_cnt), 16'd1);
        no_reboot = 1'b0;
        wr(4'd2, 16'hFFFF, 2'b11);
        wr(4'd3, 16'hFFFF, 2'b11);
        rd(4'd2, v); chk("R8 all clear", v, 16'h0000);

        // R9 mailbox
        wr(4'd1, 16'h00A5, 2'b01);
        rd(4'd2, v); chk("R9 data-in flags", v, 16'h0006);
        wr(4'd2, 16'h0006, 2'b01);
        wr(4'd1, 16'h5A00, 2'b10);
        rd(4'd2, v); chk("R9 data-out flags", v, 16'h0006);
        rd(4'd1, v); chk("R9 bytes", v, 16'h5AA5);
        wr(4'd2, 16'hFFFF, 2'b11);

        // R10 lock
        wr(4'd4, 16'h1000, 2'b11);
        wr(4'd4, 16'h0000, 2'b11);
        rd(4'd4, v); chk("R10 lock sticky", v, 16'h1000);

        // R11 mask and max count
        wr(4'd4, 16'h0800, 2'b11);
        wr(4'd9, 16'hFFFF, 2'b11);
        rd(4'd9, v); chk("R11 mask", v, 16'h03FF);
        wr(4'd0, 16'h0000, 2'b11);
        rd(4'd0, v); chk("R11 max load", v, 16'h03FF);
        wr(4'd2, 16'hFFFF, 2'b11);
        wr(4'd4, 16'h0000, 2'b11);
        tick(1022);
        rd(4'd0, v); chk("R5 max reads 1", v, 16'h0001);
        rd(4'd2, v); chk("R5 max no timeout", v, 16'h0000);
        tick(1);
        rd(4'd2, v); chk("R5 max timeout", v, 16'h0008);

        // R11 small value
        wr(4'd4, 16'h0800, 2'b11);
        wr(4'd9, 16'h0001, 2'b11);
        rd(4'd9, v); chk("R11 value 1", v, 16'h0001);
        wr(4'd0, 16'h0000, 2'b11);
        rd(4'd0, v); chk("R11 loads 2", v, 16'h0002);
        wr(4'd2, 16'hFFFF, 2'b11);
        wr(4'd4, 16'h0000, 2'b11);
        tick(1);
        rd(4'd2, v); chk("R11 no timeout at 1", v, 16'h0000);
        tick(1);
        rd(4'd2, v); chk("R11 timeout at 2", v, 16'h0008);

        finish_run();
    end
endmodule